// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a bus master that drains a ring of transmit descriptors held in a 32-bit, word-addressed memory. Software builds the descriptors, sets their hardware-ownership flag, places the ring's start address on `ring_base` and pulses `send_trig`. The engine then visits the descriptors one after another. For each one that hardware owns, it fetches the frame buffer and sends the bytes on a valid/ready byte stream. Each byte carries the descriptor's destination port bitmap. When the frame is done, the engine returns the descriptor to software by clearing the ownership flag in memory and pulses `send_done`.

A descriptor is 16 bytes, made of four words: head, second buffer, buffer length and control. The engine never reads the second-buffer word. The ring has no length register. Its end is the descriptor whose end-of-ring flag is set, and after that descriptor the engine goes back to the ring's start. Scanning stops at the first descriptor that software still owns, and the engine waits there for the next trigger.

Top module: `txring_dma`

## Requirements
- R1: After reset the engine is idle. It raises no memory request, no stream byte and no `send_done`. Its ring position is the entry at `ring_base`, so the first trigger fetches that entry first.
- R2: Descriptor layout, as word offsets from the descriptor address. Head (+0): bit 31 = owned by hardware, bit 28 = end of ring, bits 24:0 = buffer byte address. Buffer length in bytes (+2). Control (+3): bits 26:16 = frame length in bytes, bits 5:0 = destination port bitmap. All other bits are ignored.
- R3: A `send_trig` pulse in idle starts a scan. When a head word is read with bit 31 clear, the engine reads that head exactly once, goes idle and keeps its position.
- R4: Frame bytes come from consecutive byte addresses starting at the buffer address, at any alignment. Memory words are little-endian: byte address a is bits 8*(a%4)+7 : 8*(a%4) of word a/4. `tx_port_mask` carries the descriptor's bitmap with every byte.
- R5: The number of bytes sent is the smaller of the frame length and the buffer length. A frame whose count is zero sends no bytes but is still written back and reported.
- R6: `tx_last` is high on the final byte of a frame and on no other byte. While `tx_valid` is high and `tx_ready` is low, the byte and its flags hold steady.
- R7: After the last byte, the engine writes the head word back with bit 31 cleared and every other bit unchanged. Once that write is granted, `send_done` pulses for exactly one cycle, once per descriptor.
- R8: After a descriptor, the next one is 16 bytes further on. After a descriptor with the end-of-ring bit set, the next one is at `ring_base`.
- R9: A trigger that arrives while the engine is busy is remembered. When the scan would otherwise stop, the engine makes one more pass, starting with a re-read of the same head word.
- R10: A memory request keeps its address, direction and data until `mem_gnt` is seen. Read data is taken when `mem_rvalid` is high, and frames come out correctly under any grant pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of the first ring entry, 16-byte aligned |
| send_trig | input | 1 | One-cycle strobe that starts or restarts a scan |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-2 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, the cycle after the grant or later |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_port_mask | output | PORTS | Destination port bitmap of the current frame |
| send_done | output | 1 | One-cycle pulse per returned descriptor |

## Verification
The assertions check, on every cycle, the parts of the protocol that can be read from the ports at one moment. A request must hold until it is granted. A stalled byte must stay stable. `tx_last` is only seen with `tx_valid`. A write-back never sets the ownership bit. Each `send_done` follows a granted write and lasts a single cycle. Other behaviours can only be shown by the bench's scenarios, which compare the whole stream against the memory image: byte order at each alignment, clipping to the buffer length, wrapping at the end-of-ring entry, stopping at a software-owned entry, and the extra scan after a trigger that came while busy.

// File: rtl/txring_pkg.sv
package txring_pkg;
    localparam int OWN_POS    = 31;
    localparam int EOR_POS    = 28;
    localparam int PLEN_LSB   = 16;
    localparam int DESC_BYTES = 16;
    localparam int BLEN_WORD  = 2;
    localparam int CTRL_WORD  = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_BLEN,
        S_CTRL,
        S_DATA,
        S_SEND,
        S_WBACK
    } state_t;
endpackage

// File: rtl/txring_step.sv
module txring_step #(
    parameter int ADDR_W = 25
) (
    input  logic [ADDR_W-1:0] off,
    input  logic              eor,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(txring_pkg::DESC_BYTES);

    assign nxt = eor ? '0 : off + STRIDE;
endmodule

// File: rtl/txring_clip.sv
module txring_clip #(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [31:0]      buf_len,
    output logic [LEN_W-1:0] xfer_len
);
    assign xfer_len = (buf_len < 32'(pkt_len)) ? buf_len[LEN_W-1:0] : pkt_len;
endmodule

// File: rtl/txring_lane.sv
module txring_lane #(
    parameter int BYTES = 4,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [8*BYTES-1:0] word,
    input  logic [LANE_W-1:0]  lane,
    output logic [7:0]         byte_o
);
    logic [7:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int LEN_W  = 11,
    parameter int PORTS  = 6,
    localparam int WADDR_W = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  ring_base,
    input  logic               send_trig,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    output logic [PORTS-1:0]   tx_port_mask,
    output logic               send_done
);
    typedef struct packed {
        state_t            st;
        logic [ADDR_W-1:0] off;
        logic [31:0]       head;
        logic [31:0]       blen;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  sent;
        logic [PORTS-1:0]  mask;
        logic [31:0]       word;
        logic              rd_wait;
        logic              pend;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0]  desc_byte, buf_cur, off_next;
    logic [WADDR_W-1:0] desc_word;
    logic [LEN_W-1:0]   xfer_len, sent_inc;
    logic               rd_state, got;

    assign desc_byte = ring_base + r_q.off;
    assign desc_word = WADDR_W'(desc_byte >> 2);
    assign buf_cur   = r_q.head[ADDR_W-1:0] + ADDR_W'(r_q.sent);
    assign sent_inc  = r_q.sent + LEN_W'(1);

    txring_step #(.ADDR_W(ADDR_W)) u_step (
        .off (r_q.off),
        .eor (r_q.head[EOR_POS]),
        .nxt (off_next)
    );

    txring_clip #(.LEN_W(LEN_W)) u_clip (
        .pkt_len  (mem_rdata[PLEN_LSB +: LEN_W]),
        .buf_len  (r_q.blen),
        .xfer_len (xfer_len)
    );

    txring_lane #(.BYTES(4)) u_lane (
        .word   (r_q.word),
        .lane   (buf_cur[1:0]),
        .byte_o (tx_data)
    );

    assign rd_state = (r_q.st == S_HEAD) || (r_q.st == S_BLEN) ||
                      (r_q.st == S_CTRL) || (r_q.st == S_DATA);
    assign got      = r_q.rd_wait && mem_rvalid;

    always_comb begin
        mem_req   = (rd_state && !r_q.rd_wait) || (r_q.st == S_WBACK);
        mem_we    = (r_q.st == S_WBACK);
        mem_wdata = r_q.head & ~(32'd1 << OWN_POS);
        case (r_q.st)
            S_BLEN:  mem_addr = desc_word + WADDR_W'(BLEN_WORD);
            S_CTRL:  mem_addr = desc_word + WADDR_W'(CTRL_WORD);
            S_DATA:  mem_addr = WADDR_W'(buf_cur >> 2);
            default: mem_addr = desc_word;
        endcase
    end

    assign tx_valid     = (r_q.st == S_SEND);
    assign tx_last      = tx_valid && (sent_inc == r_q.len);
    assign tx_port_mask = r_q.mask;
    assign send_done    = r_q.done;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (rd_state && !r_q.rd_wait && mem_gnt) begin
            r_d.rd_wait = 1'b1;
        end
        if (got) begin
            r_d.rd_wait = 1'b0;
        end
        if (r_q.st != S_IDLE && send_trig) begin
            r_d.pend = 1'b1;
        end
        case (r_q.st)
            S_IDLE: begin
                if (send_trig) begin
                    r_d.st   = S_HEAD;
                    r_d.pend = 1'b0;
                end
            end
            S_HEAD: begin
                if (got) begin
                    r_d.head = mem_rdata;
                    if (mem_rdata[OWN_POS]) begin
                        r_d.st = S_BLEN;
                    end else if (r_q.pend || send_trig) begin
                        r_d.pend = 1'b0;
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end
            end
            S_BLEN: begin
                if (got) begin
                    r_d.blen = mem_rdata;
                    r_d.st   = S_CTRL;
                end
            end
            S_CTRL: begin
                if (got) begin
                    r_d.len  = xfer_len;
                    r_d.mask = mem_rdata[PORTS-1:0];
                    r_d.sent = '0;
                    r_d.st   = (xfer_len == '0) ? S_WBACK : S_DATA;
                end
            end
            S_DATA: begin
                if (got) begin
                    r_d.word = mem_rdata;
                    r_d.st   = S_SEND;
                end
            end
            S_SEND: begin
                if (tx_ready) begin
                    r_d.sent = sent_inc;
                    if (sent_inc == r_q.len) begin
                        r_d.st = S_WBACK;
                    end else if (buf_cur[1:0] == 2'd3) begin
                        r_d.st = S_DATA;
                    end
                end
            end
            S_WBACK: begin
                if (mem_gnt) begin
                    r_d.done = 1'b1;
                    r_d.off  = off_next;
                    r_d.st   = S_HEAD;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/txring_chk.sv
module txring_chk #(
    parameter int WADDR_W = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_gnt,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [31:0]        mem_wdata,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [7:0]         tx_data,
    input logic               tx_last,
    input logic               send_done
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R6
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R7
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    // R7
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_done |-> $past(mem_req && mem_we && mem_gnt));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_done |=> !send_done);

    // R4
    no_fetch_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);
endmodule

bind txring_dma txring_chk #(.WADDR_W(WADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .send_done (send_done)
);

// File: tb/txring_dma_bench.sv
module txring_dma_bench;
    localparam int ADDR_W = 25;
    localparam int PORTS  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = 25'h40;
    logic              send_trig = 1'b0;
    logic              mem_req, mem_we, mem_gnt = 1'b1, mem_rvalid = 1'b0;
    logic [22:0]       mem_addr;
    logic [31:0]       mem_wdata, mem_rdata = '0;
    logic              tx_valid, tx_ready = 1'b1, tx_last, send_done;
    logic [7:0]        tx_data;
    logic [PORTS-1:0]  tx_port_mask;

    always #5 clk = ~clk;

    txring_dma u_txring_dma (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .send_trig(send_trig),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .tx_port_mask(tx_port_mask), .send_done(send_done)
    );

    logic [31:0] mem [0:1023];
    int          watch_addr = -1;
    int          watch_cnt = 0;
    int          total = 0, bad = 0;
    int          cap_n = 0, done_n = 0, cyc = 0;
    bit          throttle = 0;
    logic [7:0]  cap_b [0:1023];
    logic        cap_l [0:1023];
    logic [5:0]  cap_m [0:1023];

    always @(posedge clk) begin
        mem_rvalid <= mem_req && mem_gnt && !mem_we;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[9:0]];
                if (int'(mem_addr) == watch_addr) watch_cnt <= watch_cnt + 1;
            end
        end
        if (tx_valid && tx_ready) begin
            cap_b[cap_n] <= tx_data;
            cap_l[cap_n] <= tx_last;
            cap_m[cap_n] <= tx_port_mask;
            cap_n <= cap_n + 1;
        end
        if (send_done) done_n <= done_n + 1;
    end

    always @(negedge clk) begin
        cyc++;
        mem_gnt  = throttle ? (cyc % 3 != 1) : 1'b1;
        tx_ready = throttle ? (cyc % 4 != 2) : 1'b1;
    end

    function automatic logic [7:0] bv(int a);
        return 8'(a * 13 + 5);
    endfunction

    task automatic chk(bit ok, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic put_desc(int e, bit own, bit eor, int badr, int blen, int plen, int mask);
        mem[16 + 4*e]     = (32'(own) << 31) | (32'(eor) << 28) | 32'(badr);
        mem[16 + 4*e + 1] = 32'hFFFF_FFFF;
        mem[16 + 4*e + 2] = 32'(blen);
        mem[16 + 4*e + 3] = 32'h8000_0000 | (32'(plen) << 16) | 32'(mask);
    endtask

    task automatic trig();
        @(negedge clk); send_trig = 1'b1;
        @(negedge clk); send_trig = 1'b0;
    endtask

    task automatic wait_done(int n);
        while (done_n < n) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic check_frame(string rq, int start, int n, int badr, int mask);
        int derr = 0, lerr = 0, merr = 0;
        for (int k = 0; k < n; k++) begin
            if (cap_b[start+k] !== bv(badr + k)) derr++;
            if (cap_l[start+k] !== (k == n - 1)) lerr++;
            if (cap_m[start+k] !== 6'(mask)) merr++;
        end
        chk(derr == 0, {rq, " R4 frame bytes, mismatches"}, derr, 0);
        chk(lerr == 0, {rq, " R6 last flag placement, mismatches"}, lerr, 0);
        chk(merr == 0, {rq, " R4 port mask, mismatches"}, merr, 0);
    endtask

    task automatic check_wb(string rq, int e, bit eor, int badr);
        logic [31:0] exp = (32'(eor) << 28) | 32'(badr);
        chk(mem[16 + 4*e] == exp, {rq, " R7 head write-back"}, mem[16 + 4*e], exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e, b0, d0, k, n, plen, badr;
        for (int w = 0; w < 1024; w++)
            mem[w] = {bv(4*w+3), bv(4*w+2), bv(4*w+1), bv(4*w)};
        for (int w = 16; w < 32; w++) mem[w] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_req && !tx_valid && !send_done, "R1 outputs quiet in reset", {mem_req, tx_valid, send_done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!mem_req && !tx_valid && !send_done, "R1 idle after reset", {mem_req, tx_valid, send_done}, 0);

        // R2 R3 R8: three owned entries then a software-owned one
        put_desc(0, 1, 0, 'h400, 20, 5, 'h01);
        put_desc(1, 1, 0, 'h481, 9, 9, 'h22);
        put_desc(2, 1, 0, 'h502, 64, 4, 'h3F);
        put_desc(3, 0, 1, 'h5A0, 8, 8, 'h07);
        watch_addr = 28; watch_cnt = 0;
        trig();
        wait_done(3);
        chk(done_n == 3, "R7 done pulses for three entries", done_n, 3);
        chk(cap_n == 18, "R2 total bytes of three frames", cap_n, 18);
        check_frame("R1", 0, 5, 'h400, 'h01);
        check_frame("R8", 5, 9, 'h481, 'h22);
        check_frame("R2", 14, 4, 'h502, 'h3F);
        check_wb("R7", 0, 0, 'h400);
        check_wb("R7", 2, 0, 'h502);
        chk(watch_cnt == 1, "R3 stop at software-owned head reads it once", watch_cnt, 1);
        chk(mem[28] == ((32'd1 << 28) | 32'h5A0), "R3 untouched entry keeps its head", mem[28], (32'd1 << 28) | 32'h5A0);
        chk(!mem_req && !tx_valid, "R3 engine idle after stop", {mem_req, tx_valid}, 0);

        // R5 R8: end-of-ring entry clipped, then wrap to a zero-length entry
        put_desc(3, 1, 1, 'h603, 3, 7, 'h04);
        put_desc(0, 1, 0, 'h640, 50, 0, 'h08);
        watch_addr = 20; watch_cnt = 0;
        b0 = cap_n;
        trig();
        wait_done(5);
        chk(cap_n - b0 == 3, "R5 clipped to buffer length, zero-length sends none", cap_n - b0, 3);
        check_frame("R5", b0, 3, 'h603, 'h04);
        check_wb("R8", 3, 1, 'h603);
        check_wb("R5", 0, 0, 'h640);
        chk(done_n == 5, "R5 zero-length entry still reported", done_n, 5);
        chk(watch_cnt == 1, "R8 wrap reached entry after base", watch_cnt, 1);

        // R9: trigger during a busy frame adds one more pass
        throttle = 1;
        put_desc(1, 1, 0, 'h700, 40, 30, 'h10);
        watch_addr = 24; watch_cnt = 0;
        b0 = cap_n;
        trig();
        while (cap_n < b0 + 5) @(negedge clk);
        trig();
        wait_done(6);
        check_frame("R9", b0, 30, 'h700, 'h10);
        chk(watch_cnt == 2, "R9 remembered trigger re-reads stopping head", watch_cnt, 2);
        chk(cap_n - b0 == 30, "R10 byte count under throttled grant", cap_n - b0, 30);

        // R4 R5 R6 R10: sweep alignment and length with throttling
        e = 2; k = 0;
        for (int al = 0; al < 4; al++) begin
            for (int len = 1; len <= 8; len++) begin
                plen = (len % 3 == 0) ? len + 4 : len;
                badr = 'h800 + 32*k + al;
                put_desc(e, 1, e == 3, badr, len, plen, (k % 63) + 1);
                b0 = cap_n; d0 = done_n;
                trig();
                wait_done(d0 + 1);
                n = cap_n - b0;
                chk(n == len, "R5 sweep byte count", n, len);
                check_frame("R10", b0, len, badr, (k % 63) + 1);
                check_wb("R7", e, e == 3, badr);
                e = (e + 1) % 4; k++;
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule